// File: doc/BRIEF.md
# Overlapping Condition-Bit Reduction Cascade

This block folds a vector of condition bits into a single bit by applying one logical operation (AND, OR or XOR) element by element. Each step writes back into the vector, so the vector acts as both source and destination. On every step element `i` becomes `e[i] op e[i+1]`, and the source sits one position above the destination. When the walk goes downward, every step reads the value that the step before it has just written. The partial results therefore cascade, and element 0 ends up holding the fold of all the bits from 0 to VL. When the walk goes upward, each step reads a neighbour that has not yet been modified, which gives a pairwise result.

The block handles one element per clock, so the work is strictly sequential. The full vector is available as a trace output, so the caller can observe every intermediate value. A run starts with a one-cycle `start` pulse while the unit is idle. The unit then signals completion with a one-cycle `done` pulse, and the final bit appears on `red_bit`.

Top module: `cr_cascade_reduce`

## Requirements
- R1: A `start` pulse while `busy` is low, with `len` ≥ 1, captures the vector, raises `busy` on the next cycle, and pulses `done` exactly `len` clock edges after the capturing edge. `busy` falls at that same edge.
- R2: The `op` encoding is 2'b00 = AND, 2'b01 = OR, 2'b10 = XOR. The code 2'b11 behaves exactly like XOR.
- R3: With `rev`=1 the indices run from `len`-1 down to 0. Each step reads the already updated `e[i+1]`, and `red_bit` equals op folded over the original bits 0..`len`. Under AND, a zero anywhere in that range reaches every lower element.
- R4: With `rev`=0 the indices run from 0 up to `len`-1. Each step reads the not yet modified `e[i+1]`, and `red_bit` equals the final value of element `len`-1.
- R5: An XOR run with `rev`=1 yields the parity of bits 0..`len` of the input.
- R6: Bits at indices `len` and above stay equal to the captured input. The final `trace` equals strict one-element-at-a-time execution.
- R7: With `len`=0 the capture edge also raises `done`. `trace` then equals the input unchanged, and `red_bit` equals input bit 0.
- R8: A `start` while `busy` is high is ignored, and the run in progress completes on its original data.
- R9: After reset, `busy`, `done`, `red_bit` and `trace` are all 0.
- R10: `done` lasts one cycle. While idle without `start`, `trace` and `red_bit` hold their values.
- R11: At most one bit of `trace` changes per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a reduction (ignored while busy) |
| vec_in | input | NBITS | Condition-bit vector to reduce |
| len | input | $clog2(NBITS) | Number of steps (vector length) |
| op | input | 2 | Operation select: 00 AND, 01 OR, 10/11 XOR |
| rev | input | 1 | 1 = walk from len-1 down to 0, 0 = walk upward |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle completion pulse |
| red_bit | output | 1 | Reduced result (last processed element) |
| trace | output | NBITS | Working vector with intermediate results |

## Verification
The hardest case to reach is a `start` that arrives in the middle of a run. The bench issues a second `start` with a different vector two cycles into a five-step run. It then checks that the final trace matches the first vector's sequential result. A second difficulty is that the cascade under AND, and the difference between downward and upward walks, only show up when a single bit sits exactly at the boundary index `len`. The stimulus table therefore places lone ones or zeros at `len` and at `len`+1 to separate inclusion from exclusion.

// File: rtl/cr_red_pkg.sv
// Shared types for the condition-bit reduction cascade.
// Assumes a two-bit operation code, where the spare code aliases XOR.
package cr_red_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_RSV = 2'b11
    } red_op_e;

    // Apply one reduction operation to two condition bits.
    function automatic logic red_apply(input red_op_e f, input logic a, input logic b);
        case (f)
            OP_AND:  red_apply = a & b;
            OP_OR:   red_apply = a | b;
            default: red_apply = a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/cr_red_step.sv
// One cascade step: combines element idx with element idx+1.
// Assumes an idx+1 beyond the vector reads as 0. The top never
// produces this, because len < NBITS.
module cr_red_step
    import cr_red_pkg::*;
#(
    parameter int NBITS = 32,
    localparam int IW = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] vec,
    input  logic [IW-1:0]    idx,
    input  red_op_e          f,
    output logic             nb
);
    logic [IW:0] idx_up;
    logic        a_bit;
    logic        b_bit;

    // Select the destination bit and its upper neighbour, then combine them.
    always_comb begin
        idx_up = {1'b0, idx} + {{IW{1'b0}}, 1'b1};
        a_bit  = vec[idx];
        b_bit  = (idx_up < (IW+1)'(NBITS)) ? vec[idx_up[IW-1:0]] : 1'b0;
        nb     = red_apply(f, a_bit, b_bit);
    end
endmodule

// File: rtl/cr_red_ctrl.sv
// Sequencer for the cascade: step counter, element index and direction.
// Assumes that start is honoured only while idle and that len = 0 needs no steps.
module cr_red_ctrl #(
    parameter int NBITS = 32,
    localparam int IW = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] len,
    input  logic          rev,
    output logic          busy,
    output logic          load,
    output logic          last,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] left;
    logic          down;

    // Accept a new run only when idle.
    assign load = start & ~busy;
    // The current step is the final one of the run.
    assign last = busy && (left == {{(IW-1){1'b0}}, 1'b1});

    // Track the remaining steps, the index and the walk direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
            idx  <= '0;
            down <= 1'b0;
        end else if (load) begin
            if (len != '0) begin
                busy <= 1'b1;
                left <= len;
                idx  <= rev ? len - 1'b1 : '0;
                down <= rev;
            end
        end else if (busy) begin
            left <= left - 1'b1;
            idx  <= down ? idx - 1'b1 : idx + 1'b1;
            if (last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/cr_cascade_reduce.sv
// Top of the condition-bit reduction cascade. It holds the working vector,
// applies one step per cycle at the index the sequencer gives, and
// registers the result bit and the done pulse.
// Assumes op and rev are sampled only at start. The operation is latched.
module cr_cascade_reduce
    import cr_red_pkg::*;
#(
    parameter int NBITS = 32,
    localparam int IW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] vec_in,
    input  logic [IW-1:0]    len,
    input  logic [1:0]       op,
    input  logic             rev,
    output logic             busy,
    output logic             done,
    output logic             red_bit,
    output logic [NBITS-1:0] trace
);
    logic [NBITS-1:0] work;
    red_op_e          f_q;
    logic             load;
    logic             last;
    logic [IW-1:0]    idx;
    logic             nb;

    cr_red_ctrl #(.NBITS(NBITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .rev(rev),
        .busy(busy), .load(load), .last(last), .idx(idx)
    );

    cr_red_step #(.NBITS(NBITS)) u_step (
        .vec(work), .idx(idx), .f(f_q), .nb(nb)
    );

    // Load the vector, write back one step per cycle, and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work    <= '0;
            f_q     <= OP_AND;
            red_bit <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                work <= vec_in;
                f_q  <= red_op_e'(op);
                if (len == '0) begin
                    done    <= 1'b1;
                    red_bit <= vec_in[0];
                end
            end else if (busy) begin
                work[idx] <= nb;
                if (last) begin
                    done    <= 1'b1;
                    red_bit <= nb;
                end
            end
        end
    end

    assign trace = work;
endmodule

// File: rtl/cr_red_check.sv
// Protocol and sequencing checks for cr_cascade_reduce, attached by bind.
module cr_red_check #(
    parameter int NBITS = 32,
    localparam int IW = $clog2(NBITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [NBITS-1:0] vec_in,
    input logic [IW-1:0]    len,
    input logic             busy,
    input logic             done,
    input logic [NBITS-1:0] trace
);
    p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len != '0) |=> busy);

    p_done_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_zero_len_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && len == '0) |=> (done && trace == $past(vec_in)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(trace));

    p_one_bit_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($countones(trace ^ $past(trace)) <= 1));
endmodule

bind cr_cascade_reduce cr_red_check #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in), .len(len),
    .busy(busy), .done(done), .trace(trace)
);

// File: tb/sim_cr_cascade_reduce.sv
module sim_cr_cascade_reduce;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vec_in = '0;
    logic [4:0]  len = '0;
    logic [1:0]  op = '0;
    logic        rev = 1'b0;
    logic        busy, done, red_bit;
    logic [31:0] trace;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    cr_cascade_reduce u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in), .len(len),
        .op(op), .rev(rev), .busy(busy), .done(done), .red_bit(red_bit), .trace(trace)
    );

    typedef struct packed {
        logic [31:0] v;
        logic [4:0]  n;
        logic [1:0]  f;
        logic        r;
        logic        e;
    } row_t;

    // Columns: vector, len, op, rev, expected result
    localparam row_t TBL [10] = '{
        '{32'h0000000F, 5'd3,  2'b00, 1'b1, 1'b1},  // R3 AND, bits 0..3 all set
        '{32'h00000007, 5'd3,  2'b00, 1'b1, 1'b0},  // R3 AND cascade: zero at index len
        '{32'h00000010, 5'd4,  2'b01, 1'b1, 1'b1},  // R3 OR: bit at index len is included
        '{32'h00000020, 5'd4,  2'b01, 1'b1, 1'b0},  // R3 OR: bit at len+1 is excluded
        '{32'h0000000B, 5'd3,  2'b10, 1'b1, 1'b1},  // R5 parity of 1,1,0,1
        '{32'h0000000B, 5'd3,  2'b11, 1'b1, 1'b1},  // R2 reserved code acts as XOR
        '{32'h0000000E, 5'd2,  2'b00, 1'b0, 1'b1},  // R4 forward AND, pairwise
        '{32'h00000006, 5'd2,  2'b10, 1'b0, 1'b0},  // R4 forward XOR
        '{32'hFFFFFFFF, 5'd31, 2'b10, 1'b1, 1'b0},  // R5 parity of 32 ones
        '{32'h00000002, 5'd1,  2'b01, 1'b0, 1'b1}   // R4 single step OR
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Sequential reference: returns {result, final vector}.
    function automatic logic [32:0] model(input logic [31:0] v, input int n,
                                          input logic [1:0] f, input logic r);
        logic [31:0] e;
        logic        res;
        e   = v;
        res = v[0];
        for (int s = 0; s < n; s++) begin
            int   i;
            logic b;
            i = r ? n - 1 - s : s;
            b = (i + 1 < 32) ? e[i+1] : 1'b0;
            case (f)
                2'b00:   e[i] = e[i] & b;
                2'b01:   e[i] = e[i] | b;
                default: e[i] = e[i] ^ b;
            endcase
            res = e[i];
        end
        return {res, e};
    endfunction

    // Pulse start and count edges until done. Flags any cycle where more than one trace bit changes.
    task automatic run(input logic [31:0] v, input logic [4:0] n, input logic [1:0] f,
                       input logic r, output int cyc);
        logic [31:0] prev;
        @(negedge clk);
        vec_in = v; len = n; op = f; rev = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        prev = trace;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if ($countones(trace ^ prev) > 1)
                chk("R11 single-bit step", 32'($countones(trace ^ prev)), 32'd1);
            prev = trace;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int          cyc;
        logic [32:0] m;
        logic [31:0] keep_t;
        logic        keep_r;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", 32'(busy), 0);
        chk("R9 done", 32'(done), 0);
        chk("R9 red_bit", 32'(red_bit), 0);
        chk("R9 trace", trace, 0);
        rst_n = 1'b1;

        foreach (TBL[k]) begin
            run(TBL[k].v, TBL[k].n, TBL[k].f, TBL[k].r, cyc);
            m = model(TBL[k].v, int'(TBL[k].n), TBL[k].f, TBL[k].r);
            chk("R1 latency", 32'(cyc), 32'(TBL[k].n));
            chk("R1 busy falls with done", 32'(busy), 0);
            chk("R2 result", 32'(red_bit), 32'(TBL[k].e));
            chk("R6 trace", trace, m[31:0]);
        end

        // R3 AND cascade: the zero at index 4 reaches every element below it
        run(32'h000000EF, 5'd6, 2'b00, 1'b1, cyc);
        chk("R3 cascade trace", trace, 32'h000000E0);
        chk("R3 cascade result", 32'(red_bit), 0);

        // R7 zero length
        run(32'hA5A50003, 5'd0, 2'b00, 1'b1, cyc);
        chk("R7 immediate done", 32'(cyc), 0);
        chk("R7 trace unchanged", trace, 32'hA5A50003);
        chk("R7 result is bit 0", 32'(red_bit), 1);

        // R10 hold after done
        keep_t = trace;
        keep_r = red_bit;
        repeat (3) @(negedge clk);
        chk("R10 done single pulse", 32'(done), 0);
        chk("R10 trace held", trace, keep_t);
        chk("R10 result held", 32'(red_bit), 32'(keep_r));

        // R8 start while busy is ignored
        @(negedge clk);
        vec_in = 32'h0000003F; len = 5'd5; op = 2'b00; rev = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        vec_in = 32'h00000000; len = 5'd2; op = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        m = model(32'h0000003F, 5, 2'b00, 1'b1);
        chk("R8 trace from first run", trace, m[31:0]);
        chk("R8 result from first run", 32'(red_bit), 32'(m[32]));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule